// File: doc/BRIEF.md
# Cache Line Maintenance Command Unit

This unit sits between a register write port and a virtually indexed, physically tagged cache. Software writes one word to a command register, and the unit turns it into a single-line maintenance request. The request carries the operation, the set index used to locate the line, and the physical line number used to match the tag. Three operations exist. Instruction-side invalidate drops a line. Data-side invalidate discards a line, or writes it back first, depending on the cache's own setting. Data-side flush writes a line back without dropping it.

A virtually indexed cache can hold the same physical line at several set positions when one way spans more than a page. The unit therefore has to recover the virtual bits that select among these alias positions, and an elaboration parameter picks how. In packed mode, the command word is a physical address whose unused line-offset bits carry the needed virtual page bits. In split mode, the command word is the virtual address used for indexing, and the physical address comes from a separate tag register. In physical-only mode, used for non-aliasing caches, the command word serves as both index and tag. In every mode, the upper physical bits above the 32-bit word come from a tag-high register. Both tag registers keep their values until they are rewritten, so one tag write can serve a whole run of line commands.

The cache arrays are outside the block. They consume the request through a valid/acknowledge pair. While a request is outstanding, the write port is held off with a ready signal.

Top module: `clm_line_unit`

## Requirements
- R1: After reset, `req_valid` is 0, `wr_ready` is 1, and both tag registers read as zero in any later request.
- R2: Register select codes are: 0 = instruction invalidate, 1 = data invalidate, 2 = data flush, 4 = tag-low, 5 = tag-high. A command request reports `req_op` 0, 1 or 2 for selects 0, 1 or 2 respectively.
- R3: A command write accepted (wr_en and wr_ready high at a rising edge) raises `req_valid` at that same edge, with exactly one request per accepted command.
- R4: While `req_valid` is high and `req_ack` is low, `req_op`, `req_index` and `req_tag` stay stable and `wr_ready` is low. `req_valid` falls at the edge where `req_ack` is sampled high.
- R5: A write presented while `wr_ready` is low has no effect. The pending request is neither dropped nor overwritten, and a tag write made in that state does not change the tag registers.
- R6: In packed mode (default geometry: 32-byte lines, 8 KiB pages, 2 alias bits), `req_index` = {wr_data[1:0], wr_data[12:5]}: the physical in-page line index with its top alias bits replaced by the packed virtual bits. `req_tag` = {tag_high, wr_data[31:5]}.
- R7: In split mode, `req_index` = wr_data[14:5] of the command write and `req_tag` = {tag_high, tag_low[31:5]}.
- R8: In physical-only mode, `req_index` = wr_data[14:5] and `req_tag` = {tag_high, wr_data[31:5]}, both from the command word.
- R9: The tag registers hold their values across any number of command writes.
- R10: Select codes 3, 6 and 7 launch no request and change no tag register.
- R11: A tag-high write keeps only wr_data[7:0], which form bits [34:27] of `req_tag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Write accepted when high |
| req_valid | output | 1 | Maintenance request pending |
| req_op | output | 2 | Operation: 0 instr invalidate, 1 data invalidate, 2 data flush |
| req_index | output | 10 | Set index (line granularity) |
| req_tag | output | 35 | Physical line number |
| req_ack | input | 1 | Cache accepted the pending request |

## Verification
The hardest situation to reach from the ports is a write that lands while a request is still unacknowledged. Such a write must disturb neither the held payload nor the tag registers. The stimulus withholds the acknowledge and drives both a new command and a tag-low write into the busy window for several cycles. It then confirms that the held payload is unchanged and that the next accepted command still uses the tag written earlier. All three addressing modes are elaborated side by side and driven with the same writes, so a single write sequence exposes the differences in how each mode builds the index and tag.

// File: rtl/clm_pkg.sv
package clm_pkg;

    typedef enum logic [1:0] {
        OP_IC_INV   = 2'd0,
        OP_DC_INV   = 2'd1,
        OP_DC_FLUSH = 2'd2
    } line_op_e;

    typedef enum logic [1:0] {
        MODE_PACKED = 2'd0,
        MODE_SPLIT  = 2'd1,
        MODE_PHYS   = 2'd2
    } addr_mode_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_IC_INV   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DC_INV   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DC_FLUSH = 3'd2;
    localparam logic [SEL_W-1:0] SEL_TAG_LO   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_TAG_HI   = 3'd5;

    typedef struct packed {
        logic     is_cmd;
        line_op_e op;
        logic     tag_lo_we;
        logic     tag_hi_we;
    } wr_dec_t;

    function automatic wr_dec_t decode_sel(input logic [SEL_W-1:0] sel);
        wr_dec_t d;
        d = '{is_cmd: 1'b0, op: OP_IC_INV, tag_lo_we: 1'b0, tag_hi_we: 1'b0};
        case (sel)
            SEL_IC_INV:   begin d.is_cmd = 1'b1; d.op = OP_IC_INV;   end
            SEL_DC_INV:   begin d.is_cmd = 1'b1; d.op = OP_DC_INV;   end
            SEL_DC_FLUSH: begin d.is_cmd = 1'b1; d.op = OP_DC_FLUSH; end
            SEL_TAG_LO:   d.tag_lo_we = 1'b1;
            SEL_TAG_HI:   d.tag_hi_we = 1'b1;
            default:      ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clm_tag_regs.sv
module clm_tag_regs #(
    parameter int DW   = 32,
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lo_we,
    input  logic            hi_we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   tag_lo,
    output logic [HI_W-1:0] tag_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_lo <= '0;
            tag_hi <= '0;
        end else begin
            if (lo_we) tag_lo <= wdata;
            if (hi_we) tag_hi <= wdata[HI_W-1:0];
        end
    end

endmodule

// File: rtl/clm_addr_map.sv
module clm_addr_map
    import clm_pkg::*;
#(
    parameter addr_mode_e MODE       = MODE_PACKED,
    parameter int         DW         = 32,
    parameter int         PA_W       = 40,
    parameter int         LINE_BITS  = 5,
    parameter int         PAGE_SHIFT = 13,
    parameter int         ALIAS_BITS = 2,
    localparam int        HI_W       = PA_W - DW,
    localparam int        IDX_W      = PAGE_SHIFT + ALIAS_BITS - LINE_BITS,
    localparam int        TAG_W      = PA_W - LINE_BITS,
    localparam int        IDX_TOP    = PAGE_SHIFT + ALIAS_BITS - 1
) (
    input  logic [DW-1:0]    cmd_word,
    input  logic [DW-1:0]    tag_lo,
    input  logic [HI_W-1:0]  tag_hi,
    output logic [IDX_W-1:0] index,
    output logic [TAG_W-1:0] tag
);

    generate
        if (MODE == MODE_PACKED) begin : g_packed
            if (ALIAS_BITS > 0) begin : g_alias
                assign index = {cmd_word[ALIAS_BITS-1:0],
                                cmd_word[PAGE_SHIFT-1:LINE_BITS]};
            end else begin : g_noalias
                assign index = cmd_word[PAGE_SHIFT-1:LINE_BITS];
            end
            assign tag = {tag_hi, cmd_word[DW-1:LINE_BITS]};
        end else if (MODE == MODE_SPLIT) begin : g_split
            assign index = cmd_word[IDX_TOP:LINE_BITS];
            assign tag   = {tag_hi, tag_lo[DW-1:LINE_BITS]};
        end else begin : g_phys
            assign index = cmd_word[IDX_TOP:LINE_BITS];
            assign tag   = {tag_hi, cmd_word[DW-1:LINE_BITS]};
        end
    endgenerate

endmodule

// File: rtl/clm_req_slot.sv
module clm_req_slot
    import clm_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 35
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  line_op_e         in_op,
    input  logic [IDX_W-1:0] in_index,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             ack,
    output logic             valid,
    output line_op_e         op,
    output logic [IDX_W-1:0] index,
    output logic [TAG_W-1:0] tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            op    <= OP_IC_INV;
            index <= '0;
            tag   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            op    <= in_op;
            index <= in_index;
            tag   <= in_tag;
        end else if (valid && ack) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/clm_line_unit.sv
module clm_line_unit
    import clm_pkg::*;
#(
    parameter addr_mode_e MODE       = MODE_PACKED,
    parameter int         DW         = 32,
    parameter int         PA_W       = 40,
    parameter int         LINE_BITS  = 5,
    parameter int         PAGE_SHIFT = 13,
    parameter int         ALIAS_BITS = 2,
    localparam int        HI_W       = PA_W - DW,
    localparam int        IDX_W      = PAGE_SHIFT + ALIAS_BITS - LINE_BITS,
    localparam int        TAG_W      = PA_W - LINE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_ready,
    output logic             req_valid,
    output logic [1:0]       req_op,
    output logic [IDX_W-1:0] req_index,
    output logic [TAG_W-1:0] req_tag,
    input  logic             req_ack
);

    wr_dec_t          dec;
    logic             accept;
    logic [DW-1:0]    tag_lo;
    logic [HI_W-1:0]  tag_hi;
    logic [IDX_W-1:0] map_index;
    logic [TAG_W-1:0] map_tag;
    line_op_e         slot_op;

    assign dec      = decode_sel(wr_sel);
    assign wr_ready = ~req_valid;
    assign accept   = wr_en & wr_ready;

    clm_tag_regs #(.DW(DW), .HI_W(HI_W)) u_tags (
        .clk    (clk),
        .rst    (rst),
        .lo_we  (accept & dec.tag_lo_we),
        .hi_we  (accept & dec.tag_hi_we),
        .wdata  (wr_data),
        .tag_lo (tag_lo),
        .tag_hi (tag_hi)
    );

    clm_addr_map #(
        .MODE(MODE), .DW(DW), .PA_W(PA_W), .LINE_BITS(LINE_BITS),
        .PAGE_SHIFT(PAGE_SHIFT), .ALIAS_BITS(ALIAS_BITS)
    ) u_map (
        .cmd_word (wr_data),
        .tag_lo   (tag_lo),
        .tag_hi   (tag_hi),
        .index    (map_index),
        .tag      (map_tag)
    );

    clm_req_slot #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (accept & dec.is_cmd),
        .in_op    (dec.op),
        .in_index (map_index),
        .in_tag   (map_tag),
        .ack      (req_ack),
        .valid    (req_valid),
        .op       (slot_op),
        .index    (req_index),
        .tag      (req_tag)
    );

    assign req_op = slot_op;

endmodule

// File: rtl/clm_line_unit_chk.sv
module clm_line_unit_chk #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 35
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic             wr_ready,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [IDX_W-1:0] req_index,
    input logic [TAG_W-1:0] req_tag,
    input logic             req_ack
);

    AST_READY_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !wr_ready); // R4

    AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_op)
                                     && $stable(req_index) && $stable(req_tag))); // R4

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack) |=> !req_valid); // R4

    AST_CMD_LAUNCHES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ready && wr_sel <= 3'd2) |=> req_valid); // R3

    AST_NON_CMD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ready && wr_sel > 3'd2) |=> !req_valid); // R10

    AST_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_op != 2'd3)); // R2

endmodule

bind clm_line_unit clm_line_unit_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_ready  (wr_ready),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_index (req_index),
    .req_tag   (req_tag),
    .req_ack   (req_ack)
);

// File: tb/sim_clm_line_unit.sv
module sim_clm_line_unit;
    import clm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_ack = 1'b0;

    logic        rdy [3];
    logic        vld [3];
    logic [1:0]  op  [3];
    logic [9:0]  idx [3];
    logic [34:0] tg  [3];

    int checks = 0;
    int errors = 0;
    logic [31:0] m_lo = '0;
    logic [7:0]  m_hi = '0;

    always #4 clk = ~clk;

    clm_line_unit #(.MODE(MODE_PACKED)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_ready(rdy[0]), .req_valid(vld[0]), .req_op(op[0]),
        .req_index(idx[0]), .req_tag(tg[0]), .req_ack(req_ack));
    clm_line_unit #(.MODE(MODE_SPLIT)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_ready(rdy[1]), .req_valid(vld[1]), .req_op(op[1]),
        .req_index(idx[1]), .req_tag(tg[1]), .req_ack(req_ack));
    clm_line_unit #(.MODE(MODE_PHYS)) u2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_ready(rdy[2]), .req_valid(vld[2]), .req_op(op[2]),
        .req_index(idx[2]), .req_tag(tg[2]), .req_ack(req_ack));

    typedef struct packed {
        logic [2:0]  sel;
        logic [31:0] data;
        logic [1:0]  exp_op;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h8000_1FE3, 2'd0},
        '{3'd1, 32'h0000_2047, 2'd1},
        '{3'd2, 32'hFFFF_FFE1, 2'd2},
        '{3'd0, 32'h1357_9BDF, 2'd0},
        '{3'd1, 32'h0000_0000, 2'd1},
        '{3'd2, 32'h7FFF_C01E, 2'd2}
    };

    function automatic logic [9:0] exp_idx(int m, logic [31:0] d);
        if (m == 0) return {d[1:0], d[12:5]};
        return d[14:5];
    endfunction

    function automatic logic [34:0] exp_tag(int m, logic [31:0] d);
        if (m == 1) return {m_hi, m_lo[31:5]};
        return {m_hi, d[31:5]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic check_req(input string req, input logic [31:0] d, input logic [1:0] eop);
        for (int m = 0; m < 3; m++) begin
            check({req, " valid"}, 64'(vld[m]), 64'd1);
            check({req, " op"}, 64'(op[m]), 64'(eop));
            check({req, " index"}, 64'(idx[m]), 64'(exp_idx(m, d)));
            check({req, " tag"}, 64'(tg[m]), 64'(exp_tag(m, d)));
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 64'(rdy[0]), 64'd1);
        check("R1 valid", 64'(vld[1]), 64'd0);
        // R1 tag registers zero: split tag all zero
        wr(3'd0, 32'h0000_4AC0);
        check_req("R1 zero tags", 32'h0000_4AC0, 2'd0);
        ack();

        // set tags (R11 keep low 8 bits)
        wr(3'd5, 32'hFFFF_FFA5); m_hi = 8'hA5;
        wr(3'd4, 32'h1234_5000); m_lo = 32'h1234_5000;
        check("R9 tag write no request", 64'(vld[1]), 64'd0);

        // table walk: R2 R3 R6 R7 R8 R9 R11
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].sel, VECS[i].data);
            check_req("R2/R3/R6/R7/R8", VECS[i].data, VECS[i].exp_op);
            @(negedge clk);
            check("R4 held valid", 64'(vld[0]), 64'd1);
            check("R4 held index", 64'(idx[0]), 64'(exp_idx(0, VECS[i].data)));
            check("R4 ready low", 64'(rdy[2]), 64'd0);
            ack();
            check("R4 valid falls after ack", 64'(vld[1]), 64'd0);
            check("R4 ready back", 64'(rdy[1]), 64'd1);
        end

        // R5: writes while busy ignored
        wr(3'd2, 32'h0000_6060);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_sel = 3'd4; wr_data = 32'hDEAD_BEE0;
        @(negedge clk);
        wr_en = 1'b0;
        check_req("R5 pending not overwritten", 32'h0000_6060, 2'd2);
        ack();
        check("R5 no extra request", 64'(vld[0]), 64'd0);
        wr(3'd1, 32'h0000_0FA0);
        check_req("R5 tag unchanged by busy write", 32'h0000_0FA0, 2'd1);
        ack();

        // R10: unused selects
        wr(3'd3, 32'hAAAA_AAA0);
        check("R10 sel3 no request", 64'(vld[2]), 64'd0);
        wr(3'd6, 32'hBBBB_BBB0);
        wr(3'd7, 32'hCCCC_CCC0);
        check("R10 sel7 no request", 64'(vld[0]), 64'd0);
        wr(3'd0, 32'h0000_1120);
        check_req("R10 tags untouched", 32'h0000_1120, 2'd0);
        ack();

        // R11: only low 8 bits of tag-high kept
        wr(3'd5, 32'h1234_563C); m_hi = 8'h3C;
        wr(3'd2, 32'h8765_4320);
        check_req("R11 tag-high", 32'h8765_4320, 2'd2);
        check("R11 upper tag bits", 64'(tg[1][34:27]), 64'h3C);
        ack();

        // R1: reset during pending request clears it and the tags
        wr(3'd1, 32'h0000_2220);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_hi = '0; m_lo = '0;
        check("R1 reset clears valid", 64'(vld[0]), 64'd0);
        check("R1 reset ready", 64'(rdy[1]), 64'd1);
        wr(3'd0, 32'h0000_7FE0);
        check_req("R1 tags cleared", 32'h0000_7FE0, 2'd0);
        ack();

        finish_run();
    end

endmodule